// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the local device is being addressed by the first byte that follows a start condition on an I2C bus. A shared shifter supplies the received byte, including the read/write bit, and a shared counter supplies the number of SCL falling edges since the start. When that count reaches the address length, the block compares the seven address bits with the programmed local address. It also checks whether the byte belongs to the reserved families, where the upper nibble is 0000 or 1111.

A hit on either test raises a one-cycle interrupt and sets the matching flags. A decoded type names which reserved family arrived, so software can choose its next step. Every other byte is silently ignored. The flags stay valid until the next start or stop condition. Software may also drop out of a reserved-code transfer with the release input. The block then takes no part in the bus until a new start arrives. Both plain 7-bit addressing and the first byte of a 10-bit address are covered.

Top module: `i2c_addr_match`

## Requirements
- R1: The interrupt `irq` is a single-cycle pulse. It is raised only on the clock edge at which an armed window sees `fall_cnt` equal to ADDR_EDGE (default 8) and the byte either matches the local address or is a reserved code. Any other byte gives no pulse.
- R2: `match_flag` is set when `rx_byte[7:1]` equals `own_addr`. `rw_bit` then reports `rx_byte[0]`, with 1 meaning read.
- R3: `ext_flag` is set when `rx_byte[7:4]` is 4'b0000 or 4'b1111, whatever the local address is.
- R4: `ext_kind` encodes the reserved family as follows. 0 means no reserved code. 1 is general call (8'h00). 2 is start byte (8'h01). 3 is the 0000001x group. 4 is the 0000010x alternate-format group. 5 is the 10-bit prefix 11110xxx. 6 covers every other byte whose upper nibble is 0000 or 1111.
- R5: If `own_addr` is a 10-bit prefix 11110xx and the received byte carries that same prefix, both `match_flag` and `ext_flag` are set. `ext_kind` is 5 and exactly one interrupt pulse is given.
- R6: Only the first byte after a start is evaluated. Later counts, including a repeat of ADDR_EDGE, change no flag and raise no interrupt until the next start.
- R7: A `bus_start` or `bus_stop` pulse clears every flag, `ext_kind` and `rw_bit` by the next clock. A synchronous `rst` does the same and disarms the window.
- R8: If `rel_req` is high while `ext_flag` is set, the flags are cleared and nothing more is evaluated until the next start. If `rel_req` is high while `ext_flag` is clear, it has no effect.
- R9: While the count is below ADDR_EDGE, no interrupt occurs and all flags stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_start | input | 1 | One-cycle pulse on a detected start or repeated start |
| bus_stop | input | 1 | One-cycle pulse on a detected stop |
| rx_byte | input | 8 | Received byte from the shared shifter, MSB first on the wire |
| fall_cnt | input | CNT_W | SCL falling edges counted since the start |
| own_addr | input | 7 | Programmed local slave address |
| rel_req | input | 1 | Request to leave a reserved-code transfer |
| irq | output | 1 | One-cycle interrupt pulse |
| match_flag | output | 1 | Address coincidence |
| ext_flag | output | 1 | Reserved (extension) code received |
| ext_kind | output | 3 | Reserved-code family, encoded as in R4 |
| rw_bit | output | 1 | Read/write bit of the evaluated byte |

## Verification
The bench builds the block with the default parameters: an 8-bit count and evaluation at the eighth falling edge. With those values an exhaustive sweep of all 256 address bytes fits easily in the run, once against an ordinary local address and once against a 10-bit prefix. That sweep reaches every reserved family, the combined coincidence case and the read/write reporting. With the real edge number, the bench can also push the counter past eight and back again, which exercises the single-evaluation window and the release path.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    EK_NONE   = 3'd0,
    EK_GCALL  = 3'd1,
    EK_SBYTE  = 3'd2,
    EK_CBUS   = 3'd3,
    EK_RSVD   = 3'd4,
    EK_TENBIT = 3'd5,
    EK_OTHER  = 3'd6
  } ext_kind_t;

  // upper nibble all zeros or all ones marks a reserved code
  function automatic logic nib_reserved(input logic [3:0] hi);
    return (hi == 4'h0) || (hi == 4'hF);
  endfunction

  function automatic ext_kind_t kind_of(input logic [BYTE_W-1:0] b);
    if (b[7:4] == 4'hF) return b[3] ? EK_OTHER : EK_TENBIT;
    if (b[7:4] != 4'h0) return EK_NONE;
    case (b[3:1])
      3'd0:    return b[0] ? EK_SBYTE : EK_GCALL;
      3'd1:    return EK_CBUS;
      3'd2:    return EK_RSVD;
      default: return EK_OTHER;
    endcase
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction
endpackage

// File: rtl/am_decode.sv
module am_decode
  import i2c_am_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit,
  output logic              ext,
  output ext_kind_t         kind
);
  always_comb begin
    hit  = addr_hit(rx_byte, own_addr);
    ext  = nib_reserved(rx_byte[BYTE_W-1 -: 4]);
    kind = kind_of(rx_byte);
  end
endmodule

// File: rtl/am_window.sv
module am_window #(
  parameter int CNT_W     = 8,
  parameter int ADDR_EDGE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [CNT_W-1:0] fall_cnt,
  output logic             eval_now
);
  localparam logic [CNT_W-1:0] EDGE_V = CNT_W'(ADDR_EDGE);

  logic armed_q;

  // the window opens on a start and closes after one evaluation or a stop
  always_ff @(posedge clk) begin
    if (rst)            armed_q <= 1'b0;
    else if (bus_start) armed_q <= 1'b1;
    else if (bus_stop)  armed_q <= 1'b0;
    else if (eval_now)  armed_q <= 1'b0;
  end

  always_comb
    eval_now = armed_q && !bus_start && !bus_stop && (fall_cnt == EDGE_V);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ADDR_EDGE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [CNT_W-1:0]  fall_cnt,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rel_req,
  output logic              irq,
  output logic              match_flag,
  output logic              ext_flag,
  output logic [2:0]        ext_kind,
  output logic              rw_bit
);
  logic      dec_hit, dec_ext, eval_now, rel_clear, clear_bus;
  ext_kind_t dec_kind, kind_q;

  am_decode u_dec (
    .rx_byte  (rx_byte),
    .own_addr (own_addr),
    .hit      (dec_hit),
    .ext      (dec_ext),
    .kind     (dec_kind)
  );

  am_window #(.CNT_W(CNT_W), .ADDR_EDGE(ADDR_EDGE)) u_win (
    .clk       (clk),
    .rst       (rst),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .fall_cnt  (fall_cnt),
    .eval_now  (eval_now)
  );

  assign clear_bus = bus_start || bus_stop;
  assign rel_clear = rel_req && ext_flag && !eval_now;

  always_ff @(posedge clk) begin
    if (rst || clear_bus || rel_clear) begin
      irq        <= 1'b0;
      match_flag <= 1'b0;
      ext_flag   <= 1'b0;
      kind_q     <= EK_NONE;
      rw_bit     <= 1'b0;
    end else if (eval_now) begin
      irq        <= dec_hit || dec_ext;
      match_flag <= dec_hit;
      ext_flag   <= dec_ext;
      kind_q     <= dec_kind;
      rw_bit     <= (dec_hit || dec_ext) ? rx_byte[0] : 1'b0;
    end else begin
      irq        <= 1'b0;
    end
  end

  assign ext_kind = kind_q;
endmodule

// File: rtl/am_checker.sv
module am_checker #(
  parameter int CNT_W     = 8,
  parameter int ADDR_EDGE = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_start,
  input logic             bus_stop,
  input logic             rel_req,
  input logic             eval_now,
  input logic [CNT_W-1:0] fall_cnt,
  input logic             irq,
  input logic             match_flag,
  input logic             ext_flag,
  input logic [2:0]       ext_kind
);
  assert_irq_cause_R1: assert property (@(posedge clk) disable iff (rst)
    irq |-> (match_flag || ext_flag));

  assert_irq_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_edge_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(fall_cnt) == CNT_W'(ADDR_EDGE)));

  assert_kind_flag_R4: assert property (@(posedge clk) disable iff (rst)
    ext_flag |-> (ext_kind != 3'd0));

  assert_kind_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !ext_flag |-> (ext_kind == 3'd0));

  assert_bus_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_start || bus_stop) |=> (!match_flag && !ext_flag && !irq));

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (rel_req && ext_flag && !eval_now) |=> (!ext_flag && !match_flag));

  assert_single_eval_R6: assert property (@(posedge clk) disable iff (rst)
    eval_now |=> !eval_now);
endmodule

bind i2c_addr_match am_checker #(.CNT_W(CNT_W), .ADDR_EDGE(ADDR_EDGE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .rel_req    (rel_req),
  .eval_now   (eval_now),
  .fall_cnt   (fall_cnt),
  .irq        (irq),
  .match_flag (match_flag),
  .ext_flag   (ext_flag),
  .ext_kind   (ext_kind)
);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  localparam int CNT_W = 8;
  localparam int EDGE  = 8;

  logic clk = 1'b0;
  logic rst, bus_start, bus_stop, rel_req;
  logic [7:0] rx_byte;
  logic [CNT_W-1:0] fall_cnt;
  logic [6:0] own_addr;
  logic irq, match_flag, ext_flag, rw_bit;
  logic [2:0] ext_kind;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  i2c_addr_match #(.CNT_W(CNT_W), .ADDR_EDGE(EDGE)) i_i2c_addr_match (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_byte(rx_byte), .fall_cnt(fall_cnt), .own_addr(own_addr),
    .rel_req(rel_req), .irq(irq), .match_flag(match_flag),
    .ext_flag(ext_flag), .ext_kind(ext_kind), .rw_bit(rw_bit)
  );

  // reference classification written from the requirement text
  function automatic int ref_kind(input int b);
    if (b == 0) return 1;
    if (b == 1) return 2;
    if (b >= 2 && b <= 3) return 3;
    if (b >= 4 && b <= 5) return 4;
    if (b >= 6 && b <= 15) return 6;
    if (b >= 240 && b <= 247) return 5;
    if (b >= 248) return 6;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // start, count edges 1..EDGE; returns with results visible
  task automatic send_byte(input logic [7:0] b, output int early_bad);
    early_bad = 0;
    bus_start = 1'b1; fall_cnt = '0; rx_byte = b;
    tick();
    bus_start = 1'b0;
    for (int i = 1; i < EDGE; i++) begin
      fall_cnt = CNT_W'(i);
      tick();
      if (irq || match_flag || ext_flag) early_bad++;
    end
    fall_cnt = CNT_W'(EDGE);
    tick();
  endtask

  task automatic t_reset();
    check("R7", {irq, match_flag, ext_flag, rw_bit}, 0, "flags after reset");
    check("R7", ext_kind, 0, "kind after reset");
  endtask

  task automatic t_sweep(input logic [6:0] own);
    int early;
    int bad_irq, bad_flags, bad_pulse, bad_early;
    bad_irq = 0; bad_flags = 0; bad_pulse = 0; bad_early = 0;
    own_addr = own;
    for (int b = 0; b < 256; b++) begin
      int em, ee, ek;
      send_byte(8'(b), early);
      bad_early += early;
      em = (b[7:1] == own) ? 1 : 0;
      ek = ref_kind(b);
      ee = (ek != 0) ? 1 : 0;
      if (irq !== ((em | ee) != 0)) begin
        bad_irq++;
        $display("FAIL R1 byte %0d irq: actual %0d expected %0d", b, irq, em | ee);
      end
      if (match_flag !== em[0] || ext_flag !== ee[0] || int'(ext_kind) != ek ||
          ((em | ee) != 0 && rw_bit !== b[0])) begin
        bad_flags++;
        $display("FAIL R2 R3 R4 byte %0d: actual m%0d e%0d k%0d rw%0d expected m%0d e%0d k%0d rw%0d",
                 b, match_flag, ext_flag, ext_kind, rw_bit, em, ee, ek, b[0]);
      end
      fall_cnt = CNT_W'(EDGE + 1);
      tick();
      if (irq) bad_pulse++;
    end
    check("R1", bad_irq, 0, "interrupt mismatches in sweep");
    check("R2", bad_flags, 0, "flag mismatches in sweep (R3 R4)");
    check("R1", bad_pulse, 0, "interrupt longer than one cycle");
    check("R9", bad_early, 0, "activity before edge count reached");
  endtask

  task automatic t_combined();
    int early, pulses;
    own_addr = 7'b1111010;
    send_byte(8'hF4, early);
    check("R5", {match_flag, ext_flag}, 3, "both flags for 10-bit prefix");
    check("R5", ext_kind, 5, "kind for 10-bit prefix");
    pulses = irq ? 1 : 0;
    for (int i = 0; i < 4; i++) begin
      fall_cnt = CNT_W'(EDGE + 1 + i);
      tick();
      if (irq) pulses++;
    end
    check("R5", pulses, 1, "interrupt pulses for combined case");
  endtask

  task automatic t_late_edges();
    int early, seen;
    own_addr = 7'h2A;
    send_byte(8'h54, early);
    check("R6", match_flag, 1, "first byte matched");
    rx_byte = 8'h00;
    seen = 0;
    for (int i = 1; i <= EDGE + 2; i++) begin
      fall_cnt = CNT_W'(i);
      tick();
      if (irq || ext_flag || !match_flag) seen++;
    end
    check("R6", seen, 0, "second byte changed state");
  endtask

  task automatic t_clear();
    int early;
    own_addr = 7'h2A;
    send_byte(8'h55, early);
    check("R2", rw_bit, 1, "read bit reported");
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    check("R7", {match_flag, ext_flag, rw_bit}, 0, "stop clears flags");
    send_byte(8'h00, early);
    check("R7", ext_flag, 1, "general call flagged before start");
    bus_start = 1'b1; fall_cnt = '0; tick(); bus_start = 1'b0;
    check("R7", {match_flag, ext_flag}, 0, "start clears flags");
    check("R7", ext_kind, 0, "start clears kind");
    send_byte(8'h54, early);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R7", {irq, match_flag, ext_flag, rw_bit}, 0, "reset clears flags");
    fall_cnt = CNT_W'(EDGE); tick();
    check("R7", {irq, match_flag}, 0, "reset disarms window");
  endtask

  task automatic t_release();
    int early, seen;
    own_addr = 7'h2A;
    send_byte(8'h00, early);
    check("R8", ext_flag, 1, "general call before release");
    rel_req = 1'b1; tick(); rel_req = 1'b0;
    check("R8", {match_flag, ext_flag}, 0, "release clears flags");
    seen = 0;
    rx_byte = 8'h54;
    for (int i = 1; i <= EDGE; i++) begin
      fall_cnt = CNT_W'(i);
      tick();
      if (irq || match_flag || ext_flag) seen++;
    end
    check("R8", seen, 0, "activity after release before start");
    send_byte(8'h54, early);
    rel_req = 1'b1; tick(); rel_req = 1'b0;
    check("R8", match_flag, 1, "release without reserved code ignored");
  endtask

  initial begin
    rst = 1'b1; bus_start = 1'b0; bus_stop = 1'b0; rel_req = 1'b0;
    rx_byte = '0; fall_cnt = '0; own_addr = 7'h2A;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_sweep(7'h2A);
    t_sweep(7'b1111001);
    t_combined();
    t_late_edges();
    t_clear();
    t_release();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule